// File: doc/BRIEF.md
# Request-Paced Single-Channel DMA Engine

This block is one DMA channel that copies data between two memory regions under the pacing of a peripheral. Software programs a transfer descriptor through a small word-addressed register port. The descriptor holds the source and destination addresses, the access size on each side, signed per-access address strides, the byte count of one minor loop, a starting iteration count and two signed end-of-major-loop address corrections. Each one-cycle pulse on the peripheral request input moves one minor loop, provided hardware requests are enabled. After the iteration count has run down, the major loop is complete. The current count then reloads, so a circular buffer keeps running with no software action.

The two sides may use different access widths. A holding register of eight bytes packs narrow reads into wide writes, or splits wide reads into narrow writes. Bytes keep their order, little-endian, with data right-justified on the memory data lines. The descriptor is checked each time a minor loop is about to start. Misaligned addresses or an unusable byte count set sticky error bits and cause the request to be dropped. Completion and half-completion raise an interrupt flag when enabled.

Top module: `dma_chan`

## Requirements
- R1: Register words, all zero after reset: 0 source address (reads back the live address), 1 destination address (live), 2 sizes ([1:0] source code, [5:4] destination code), 3 strides ([15:0] source, [31:16] destination, two's complement), 4 minor-loop bytes [15:0], 5 source end correction, 6 destination end correction, 7 start count (a write also loads the current count), 8 current count (read-only), 9 control ([0] request enable, [1] completion interrupt enable, [2] half interrupt enable), 10 status ([0] done, [1] interrupt flag, [2] busy; writing 1 to bit 0 or bit 1 clears that bit), 11 error ([0] source misaligned, [1] destination misaligned, [2] byte count bad; writing 1 clears a bit).
- R2: Each request pulse taken while enabled moves exactly the minor-loop byte count. Done rises only after the start-count-th minor loop.
- R3: The current count drops by one per minor loop and reloads from the start count when it reaches zero. A later request then starts a new major loop and clears done.
- R4: After every source read the source address adds the source stride. After every destination write the destination address adds the destination stride.
- R5: When the major loop completes, the source and destination addresses additionally add their end corrections.
- R6: Size codes 0..3 mean 1, 2, 4 and 8 bytes. Within a minor loop the bytes written equal the bytes read, in order, for every pair of sizes. The number of writes is the byte count divided by the destination size.
- R7: Done is set on major completion. If the completion interrupt is enabled, the interrupt flag (irq_o) is also set. The flag stays set until software clears it.
- R8: With the half interrupt enabled, the flag is set when the current count becomes half of the start count (integer halving, nonzero).
- R9: A minor loop is refused if the source address is not aligned to the source size, the destination address is not aligned to the destination size, or the byte count is zero or not a multiple of the larger size. The matching error bits are set, the request is dropped, and no memory access or count change happens. While any error bit is set, every request is dropped.
- R10: With request enable clear, request pulses are ignored and not stored. Setting the enable again resumes from the current count and addresses.
- R11: Request pulses that arrive during a minor loop are stored (up to 7) and each one is later serviced exactly once.
- R12: A memory request keeps address, direction and size stable until it is acknowledged. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| dreq_i | input | 1 | Peripheral request, one pulse per minor loop |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | 64 | Write data, right-justified |
| mem_ack_i | input | 1 | Access acknowledge; read data valid with it |
| mem_rdata_i | input | 64 | Read data, right-justified |
| irq_o | output | 1 | Interrupt flag |
| done_o | output | 1 | Major loop done |

## Verification
Several functions can fall in the same cycle. A request pulse can arrive in the very cycle the sequencer finishes a minor loop and decrements the count, or while it is consuming a stored request. The bench provokes this with back-to-back pulses and checks that the final count and the number of writes match the number of pulses exactly. A completed major loop can also coincide with the start of the next one in circular use. The bench checks that the reloaded count, the end-corrected addresses and the done flag being cleared by the new loop all agree after the extra request.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int BUS_BYTES = 8;
  localparam int DATA_W    = BUS_BYTES * 8;

  localparam int ERR_SRC = 0;
  localparam int ERR_DST = 1;
  localparam int ERR_NB  = 2;

  typedef enum logic [3:0] {
    RA_SRC   = 4'd0,
    RA_DST   = 4'd1,
    RA_SIZE  = 4'd2,
    RA_OFF   = 4'd3,
    RA_NB    = 4'd4,
    RA_SLAST = 4'd5,
    RA_DLAST = 4'd6,
    RA_BITER = 4'd7,
    RA_CITER = 4'd8,
    RA_CTRL  = 4'd9,
    RA_STAT  = 4'd10,
    RA_ERR   = 4'd11
  } reg_addr_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic half_en;
    logic major_en;
    logic hw_en;
  } ctrl_t;
endpackage

// File: rtl/dma_chan_check.sv
module dma_chan_check
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NB_W   = 16
) (
  input  logic [ADDR_W-1:0] saddr_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [1:0]        ssize_i,
  input  logic [1:0]        dsize_i,
  input  logic [NB_W-1:0]   nbytes_i,
  output logic [2:0]        err_o
);
  logic [1:0] mcode;
  logic [3:0] smask, dmask, mmask;

  always_comb begin
    mcode = (ssize_i > dsize_i) ? ssize_i : dsize_i;
    smask = (4'd1 << ssize_i) - 4'd1;
    dmask = (4'd1 << dsize_i) - 4'd1;
    mmask = (4'd1 << mcode) - 4'd1;
    err_o = '0;
    err_o[ERR_SRC] = |(saddr_i[3:0] & smask);
    err_o[ERR_DST] = |(daddr_i[3:0] & dmask);
    err_o[ERR_NB]  = (nbytes_i == '0) || (|(nbytes_i[3:0] & mmask));
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 9,
  parameter int NB_W   = 16,
  parameter int OFF_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [ADDR_W-1:0] saddr_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [CNT_W-1:0]  citer_i,
  input  logic              busy_i,
  input  logic              done_set_i,
  input  logic              done_clr_i,
  input  logic              int_set_i,
  input  logic [2:0]        err_set_i,
  output logic [1:0]        ssize_o,
  output logic [1:0]        dsize_o,
  output logic [OFF_W-1:0]  soff_o,
  output logic [OFF_W-1:0]  doff_o,
  output logic [NB_W-1:0]   nbytes_o,
  output logic [ADDR_W-1:0] slast_o,
  output logic [ADDR_W-1:0] dlast_o,
  output logic [CNT_W-1:0]  biter_o,
  output ctrl_t             ctrl_o,
  output logic [2:0]        err_o,
  output logic              done_o,
  output logic              int_o,
  output logic              wr_src_o,
  output logic              wr_dst_o,
  output logic              wr_biter_o
);
  logic wr_size, wr_off, wr_nb, wr_slast, wr_dlast, wr_ctrl, wr_stat, wr_err;

  always_comb begin
    wr_src_o   = reg_we_i && (reg_addr_i == RA_SRC);
    wr_dst_o   = reg_we_i && (reg_addr_i == RA_DST);
    wr_size    = reg_we_i && (reg_addr_i == RA_SIZE);
    wr_off     = reg_we_i && (reg_addr_i == RA_OFF);
    wr_nb      = reg_we_i && (reg_addr_i == RA_NB);
    wr_slast   = reg_we_i && (reg_addr_i == RA_SLAST);
    wr_dlast   = reg_we_i && (reg_addr_i == RA_DLAST);
    wr_biter_o = reg_we_i && (reg_addr_i == RA_BITER);
    wr_ctrl    = reg_we_i && (reg_addr_i == RA_CTRL);
    wr_stat    = reg_we_i && (reg_addr_i == RA_STAT);
    wr_err     = reg_we_i && (reg_addr_i == RA_ERR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ssize_o  <= '0;
      dsize_o  <= '0;
      soff_o   <= '0;
      doff_o   <= '0;
      nbytes_o <= '0;
      slast_o  <= '0;
      dlast_o  <= '0;
      biter_o  <= '0;
      ctrl_o   <= '0;
    end else begin
      if (wr_size) begin
        ssize_o <= reg_wdata_i[1:0];
        dsize_o <= reg_wdata_i[5:4];
      end
      if (wr_off) begin
        soff_o <= reg_wdata_i[OFF_W-1:0];
        doff_o <= reg_wdata_i[2*OFF_W-1:OFF_W];
      end
      if (wr_nb)      nbytes_o <= reg_wdata_i[NB_W-1:0];
      if (wr_slast)   slast_o  <= reg_wdata_i[ADDR_W-1:0];
      if (wr_dlast)   dlast_o  <= reg_wdata_i[ADDR_W-1:0];
      if (wr_biter_o) biter_o  <= reg_wdata_i[CNT_W-1:0];
      if (wr_ctrl)    ctrl_o   <= ctrl_t'(reg_wdata_i[2:0]);
    end
  end

  // hardware set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      int_o  <= 1'b0;
      err_o  <= '0;
    end else begin
      if (done_set_i) done_o <= 1'b1;
      else if (done_clr_i || (wr_stat && reg_wdata_i[0])) done_o <= 1'b0;
      if (int_set_i) int_o <= 1'b1;
      else if (wr_stat && reg_wdata_i[1]) int_o <= 1'b0;
      err_o <= (err_o & ~(wr_err ? reg_wdata_i[2:0] : 3'b000)) | err_set_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_SRC:   reg_rdata_o = REG_W'(saddr_i);
      RA_DST:   reg_rdata_o = REG_W'(daddr_i);
      RA_SIZE:  reg_rdata_o = REG_W'({dsize_o, 2'b00, ssize_o});
      RA_OFF:   reg_rdata_o = REG_W'({doff_o, soff_o});
      RA_NB:    reg_rdata_o = REG_W'(nbytes_o);
      RA_SLAST: reg_rdata_o = REG_W'(slast_o);
      RA_DLAST: reg_rdata_o = REG_W'(dlast_o);
      RA_BITER: reg_rdata_o = REG_W'(biter_o);
      RA_CITER: reg_rdata_o = REG_W'(citer_i);
      RA_CTRL:  reg_rdata_o = REG_W'(ctrl_o);
      RA_STAT:  reg_rdata_o = REG_W'({busy_i, int_o, done_o});
      RA_ERR:   reg_rdata_o = REG_W'(err_o);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 9,
  parameter int NB_W   = 16,
  parameter int OFF_W  = 16,
  parameter int PEND_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ssize_i,
  input  logic [1:0]        dsize_i,
  input  logic [OFF_W-1:0]  soff_i,
  input  logic [OFF_W-1:0]  doff_i,
  input  logic [NB_W-1:0]   nbytes_i,
  input  logic [ADDR_W-1:0] slast_i,
  input  logic [ADDR_W-1:0] dlast_i,
  input  logic [CNT_W-1:0]  biter_i,
  input  ctrl_t             ctrl_i,
  input  logic [2:0]        err_reg_i,
  input  logic [2:0]        chk_err_i,
  input  logic              wr_src_i,
  input  logic              wr_dst_i,
  input  logic              wr_biter_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              dreq_i,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] saddr_o,
  output logic [CNT_W-1:0]  citer_o,
  output logic [ADDR_W-1:0] daddr_o,
  output logic              busy_o,
  output logic              done_set_o,
  output logic              done_clr_o,
  output logic              int_set_o,
  output logic [2:0]        err_set_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  seq_state_e        state_q;
  logic [PEND_W-1:0] pend_q;
  logic [2:0]        rd_idx_q, wr_idx_q;
  logic [NB_W-1:0]   left_q;
  logic [DATA_W-1:0] hold_q, hold_d;

  logic [1:0]  mcode;
  logic [3:0]  maxb, rd_per, wr_per, rd_off, wr_off;
  logic        take, start_ok, rd_ack, wr_ack, last_rd, last_wr, loop_end;
  logic        major_end, half_hit, pend_inc;
  logic [CNT_W-1:0]  citer_dec;
  logic [ADDR_W-1:0] soff_x, doff_x;

  always_comb begin
    mcode     = (ssize_i > dsize_i) ? ssize_i : dsize_i;
    maxb      = 4'd1 << mcode;
    rd_per    = 4'd1 << (mcode - ssize_i);
    wr_per    = 4'd1 << (mcode - dsize_i);
    rd_off    = {1'b0, rd_idx_q} << ssize_i;
    wr_off    = {1'b0, wr_idx_q} << dsize_i;
    soff_x    = {{(ADDR_W-OFF_W){soff_i[OFF_W-1]}}, soff_i};
    doff_x    = {{(ADDR_W-OFF_W){doff_i[OFF_W-1]}}, doff_i};
    take      = (state_q == S_IDLE) && ctrl_i.hw_en && (pend_q != '0);
    start_ok  = take && (err_reg_i == '0) && (chk_err_i == '0);
    rd_ack    = (state_q == S_RD) && mem_ack_i;
    wr_ack    = (state_q == S_WR) && mem_ack_i;
    last_rd   = rd_ack && ({1'b0, rd_idx_q} == rd_per - 4'd1);
    last_wr   = wr_ack && ({1'b0, wr_idx_q} == wr_per - 4'd1);
    loop_end  = last_wr && (left_q == NB_W'(maxb));
    citer_dec = citer_o - CNT_W'(1);
    major_end = loop_end && (citer_dec == '0);
    half_hit  = loop_end && (citer_dec != '0) && (citer_dec == (biter_i >> 1));
    pend_inc  = dreq_i && ctrl_i.hw_en && (pend_q != PEND_MAX);
  end

  // pack incoming read bytes into the holding register
  always_comb begin
    hold_d = hold_q;
    for (int b = 0; b < BUS_BYTES; b++) begin
      if (b >= int'(rd_off) && b < int'(rd_off) + (1 << ssize_i))
        hold_d[b*8 +: 8] = mem_rdata_i[(b - int'(rd_off))*8 +: 8];
    end
  end

  always_comb begin
    mem_req_o   = (state_q != S_IDLE);
    mem_we_o    = (state_q == S_WR);
    mem_addr_o  = (state_q == S_WR) ? daddr_o : saddr_o;
    mem_size_o  = (state_q == S_WR) ? dsize_i : ssize_i;
    mem_wdata_o = hold_q >> {wr_off, 3'b000};
    busy_o      = (state_q != S_IDLE) || ((pend_q != '0) && ctrl_i.hw_en);
    done_set_o  = major_end;
    done_clr_o  = start_ok;
    int_set_o   = (major_end && ctrl_i.major_en) || (half_hit && ctrl_i.half_en);
    err_set_o   = take ? chk_err_i : 3'b000;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      pend_q   <= '0;
      rd_idx_q <= '0;
      wr_idx_q <= '0;
      left_q   <= '0;
      hold_q   <= '0;
    end else begin
      pend_q <= pend_q + PEND_W'(pend_inc) - PEND_W'(take);
      if (rd_ack) hold_q <= hold_d;
      case (state_q)
        S_IDLE: if (start_ok) begin
          state_q  <= S_RD;
          rd_idx_q <= '0;
          wr_idx_q <= '0;
          left_q   <= nbytes_i;
        end
        S_RD: if (rd_ack) begin
          if (last_rd) begin
            state_q  <= S_WR;
            wr_idx_q <= '0;
          end else begin
            rd_idx_q <= rd_idx_q + 3'd1;
          end
        end
        S_WR: if (wr_ack) begin
          if (loop_end) begin
            state_q <= S_IDLE;
          end else if (last_wr) begin
            state_q  <= S_RD;
            rd_idx_q <= '0;
            left_q   <= left_q - NB_W'(maxb);
          end else begin
            wr_idx_q <= wr_idx_q + 3'd1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // live addresses and current count; software write takes priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saddr_o <= '0;
      daddr_o <= '0;
      citer_o <= '0;
    end else begin
      if (wr_src_i)       saddr_o <= wdata_i;
      else if (rd_ack)    saddr_o <= saddr_o + soff_x;
      else if (major_end) saddr_o <= saddr_o + slast_i;

      if (wr_dst_i)       daddr_o <= wdata_i;
      else if (wr_ack)    daddr_o <= daddr_o + doff_x + (major_end ? dlast_i : '0);

      if (wr_biter_i)     citer_o <= wdata_i[CNT_W-1:0];
      else if (loop_end)  citer_o <= major_end ? biter_i : citer_dec;
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 9,
  parameter int NB_W   = 16,
  parameter int OFF_W  = 16,
  parameter int PEND_W = 3,
  parameter int REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              dreq_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              irq_o,
  output logic              done_o
);
  logic [1:0]        ssize, dsize;
  logic [OFF_W-1:0]  soff, doff;
  logic [NB_W-1:0]   nbytes;
  logic [ADDR_W-1:0] slast, dlast, saddr, daddr;
  logic [CNT_W-1:0]  biter, citer;
  ctrl_t             ctrl;
  logic [2:0]        err_q, chk_err, err_set;
  logic              busy, done_set, done_clr, int_set;
  logic              wr_src, wr_dst, wr_biter;

  dma_chan_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NB_W(NB_W), .OFF_W(OFF_W), .REG_W(REG_W)
  ) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .saddr_i(saddr), .daddr_i(daddr), .citer_i(citer), .busy_i(busy),
    .done_set_i(done_set), .done_clr_i(done_clr), .int_set_i(int_set),
    .err_set_i(err_set),
    .ssize_o(ssize), .dsize_o(dsize), .soff_o(soff), .doff_o(doff),
    .nbytes_o(nbytes), .slast_o(slast), .dlast_o(dlast), .biter_o(biter),
    .ctrl_o(ctrl), .err_o(err_q), .done_o(done_o), .int_o(irq_o),
    .wr_src_o(wr_src), .wr_dst_o(wr_dst), .wr_biter_o(wr_biter)
  );

  dma_chan_check #(.ADDR_W(ADDR_W), .NB_W(NB_W)) u_check (
    .saddr_i(saddr), .daddr_i(daddr), .ssize_i(ssize), .dsize_i(dsize),
    .nbytes_i(nbytes), .err_o(chk_err)
  );

  dma_chan_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NB_W(NB_W), .OFF_W(OFF_W), .PEND_W(PEND_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .ssize_i(ssize), .dsize_i(dsize), .soff_i(soff), .doff_i(doff),
    .nbytes_i(nbytes), .slast_i(slast), .dlast_i(dlast), .biter_i(biter),
    .ctrl_i(ctrl), .err_reg_i(err_q), .chk_err_i(chk_err),
    .wr_src_i(wr_src), .wr_dst_i(wr_dst), .wr_biter_i(wr_biter),
    .wdata_i(reg_wdata_i[ADDR_W-1:0]), .dreq_i,
    .mem_ack_i, .mem_rdata_i, .mem_req_o, .mem_we_o, .mem_addr_o,
    .mem_size_o, .mem_wdata_o,
    .saddr_o(saddr), .citer_o(citer), .daddr_o(daddr), .busy_o(busy),
    .done_set_o(done_set), .done_clr_o(done_clr), .int_set_o(int_set),
    .err_set_o(err_set)
  );
endmodule

// File: rtl/dma_chan_sva.sv
module dma_chan_sva #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_i,
  input logic              mem_ack_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [1:0]        mem_size_i,
  input logic [2:0]        err_i,
  input logic              done_i,
  input logic              irq_i,
  input logic [CNT_W-1:0]  citer_i,
  input logic [CNT_W-1:0]  biter_i,
  input logic [2:0]        ctrl_i
);
  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ack_i |=> mem_req_i && $stable(mem_addr_i)
      && $stable(mem_we_i) && $stable(mem_size_i));

  a_r9_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i != 3'b000) |-> !mem_req_i);

  a_r3_reload_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> (citer_i == biter_i));

  a_r7_irq_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> (ctrl_i[1] || ctrl_i[2]));

  a_r10_no_start_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[0] && !mem_req_i |=> !mem_req_i);
endmodule

bind dma_chan dma_chan_sva #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_i(mem_req_o), .mem_ack_i(mem_ack_i),
  .mem_we_i(mem_we_o), .mem_addr_i(mem_addr_o), .mem_size_i(mem_size_o),
  .err_i(err_q), .done_i(done_o), .irq_i(irq_o), .citer_i(citer),
  .biter_i(biter), .ctrl_i(ctrl)
);

// File: tb/dma_chan_test.sv
module dma_chan_test;
  localparam int CLK_P = 10;
  localparam logic [3:0] A_SRC = 4'd0, A_DST = 4'd1, A_SIZE = 4'd2, A_OFF = 4'd3,
    A_NB = 4'd4, A_SLAST = 4'd5, A_DLAST = 4'd6, A_BITER = 4'd7, A_CITER = 4'd8,
    A_CTRL = 4'd9, A_STAT = 4'd10, A_ERR = 4'd11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dreq = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata, mem_rdata;
  logic        irq, done;

  logic [7:0]  mem [256];
  int          wcnt = 0;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dreq_i(dreq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .irq_o(irq), .done_o(done)
  );

  // byte memory, one-cycle acknowledge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= '0;
      for (int k = 0; k < (1 << mem_size); k++) begin
        if (mem_we) mem[8'(mem_addr[7:0] + 8'(k))] <= mem_wdata[k*8 +: 8];
        else mem_rdata[k*8 +: 8] <= mem[8'(mem_addr[7:0] + 8'(k))];
      end
      if (mem_we) wcnt <= wcnt + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 37 + s * 11 + 5) & 255);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    dreq = 1'b1;
    repeat (n) @(negedge clk);
    dreq = 1'b0;
  endtask

  task automatic settle();
    logic [31:0] s;
    int n = 0;
    do begin
      rd(A_STAT, s);
      n++;
    end while (s[2] && n < 4000);
    if (n >= 4000) check("settle timeout", 32'd1, 32'd0);
  endtask

  task automatic fill(input int base, input int n, input int seed);
    for (int i = 0; i < n; i++) mem[8'(base + i)] <= pat(i, seed);
    @(negedge clk);
  endtask

  task automatic clr(input int base, input int n);
    for (int i = 0; i < n; i++) mem[8'(base + i)] <= 8'h00;
    @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] size,
                       input logic [31:0] off, input logic [31:0] nb, input logic [31:0] sl,
                       input logic [31:0] dl, input logic [31:0] bi, input logic [31:0] ctl);
    wr(A_CTRL, 32'd0);
    wr(A_SRC, src); wr(A_DST, dst); wr(A_SIZE, size); wr(A_OFF, off);
    wr(A_NB, nb); wr(A_SLAST, sl); wr(A_DLAST, dl); wr(A_BITER, bi);
    wr(A_STAT, 32'd3); wr(A_ERR, 32'd7);
    wr(A_CTRL, ctl);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w0, bad, sb, db;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of every register
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      check($sformatf("R1 reset reg %0d", a), v, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    check("R1 reset mem_req", {31'd0, mem_req}, 32'd0);

    // R6/R2/R5/R3: sweep every pair of access sizes
    for (int ss = 0; ss < 4; ss++) begin
      for (int ds = 0; ds < 4; ds++) begin
        sb = 1 << ss; db = 1 << ds;
        fill(0, 32, ss * 4 + ds);
        clr(8'h80, 32);
        setup(32'h0, 32'h80, 32'(ss | (ds << 4)), {16'(db), 16'(sb)}, 32'd16,
              32'hFFFF_FFE0, 32'hFFFF_FFE0, 32'd2, 32'd1);
        w0 = wcnt;
        pulse(1); settle();
        pulse(1); settle();
        bad = 0;
        for (int i = 0; i < 32; i++)
          if (mem[8'(8'h80 + i)] !== pat(i, ss * 4 + ds)) bad++;
        check($sformatf("R6 data ss%0d ds%0d", ss, ds), 32'(bad), 32'd0);
        check($sformatf("R6 write count ss%0d ds%0d", ss, ds), 32'(wcnt - w0), 32'(32 / db));
        rd(A_SRC, v); check($sformatf("R5 src wrap ss%0d ds%0d", ss, ds), v, 32'h0);
        rd(A_DST, v); check($sformatf("R5 dst wrap ss%0d ds%0d", ss, ds), v, 32'h80);
        rd(A_CITER, v); check($sformatf("R3 reload ss%0d ds%0d", ss, ds), v, 32'd2);
        check($sformatf("R2 done ss%0d ds%0d", ss, ds), {31'd0, done}, 32'd1);
      end
    end

    // R2/R4: pacing, four requests of 8 bytes
    fill(0, 32, 50); clr(8'h80, 32);
    setup(32'h0, 32'h80, 32'h22, 32'h0004_0004, 32'd8, 32'd0, 32'd0, 32'd4, 32'd1);
    for (int k = 1; k <= 4; k++) begin
      pulse(1); settle();
      rd(A_CITER, v); check($sformatf("R3 count after %0d", k), v, (k == 4) ? 32'd4 : 32'(4 - k));
      check($sformatf("R2 done after %0d", k), {31'd0, done}, (k == 4) ? 32'd1 : 32'd0);
      rd(A_DST, v); check($sformatf("R4 dst after %0d", k), v, 32'(8'h80 + 8 * k));
    end
    bad = 0;
    for (int i = 0; i < 32; i++) if (mem[8'(8'h80 + i)] !== pat(i, 50)) bad++;
    check("R2 paced data", 32'(bad), 32'd0);

    // R8: half interrupt only
    setup(32'h0, 32'h80, 32'h22, 32'h0004_0004, 32'd8, 32'd0, 32'd0, 32'd4, 32'd5);
    pulse(1); settle(); check("R8 no irq at 3", {31'd0, irq}, 32'd0);
    pulse(1); settle(); check("R8 irq at half", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'd2); @(negedge clk); check("R7 irq cleared", {31'd0, irq}, 32'd0);
    pulse(1); settle(); pulse(1); settle();
    check("R8 no irq at major when disabled", {31'd0, irq}, 32'd0);
    check("R7 done without irq", {31'd0, done}, 32'd1);

    // R7/R3: major interrupt and circular restart
    setup(32'h0, 32'h80, 32'h22, 32'h0004_0004, 32'd8, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'd2, 32'd3);
    pulse(1); settle();
    check("R7 irq mid", {31'd0, irq}, 32'd0);
    pulse(1); settle();
    check("R7 irq at major", {31'd0, irq}, 32'd1);
    check("R7 done at major", {31'd0, done}, 32'd1);
    pulse(1); settle();
    check("R3 done cleared by new loop", {31'd0, done}, 32'd0);
    rd(A_CITER, v); check("R3 new major count", v, 32'd1);
    rd(A_SRC, v); check("R5 src after restart", v, 32'd8);
    check("R7 irq sticky", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'd2); @(negedge clk); check("R7 irq w1c", {31'd0, irq}, 32'd0);

    // R9: descriptor errors
    setup(32'h1, 32'h80, 32'h22, 32'h0004_0004, 32'd8, 32'd0, 32'd0, 32'd4, 32'd1);
    w0 = wcnt;
    pulse(1); settle();
    rd(A_ERR, v); check("R9 src misaligned", v, 32'd1);
    check("R9 no writes", 32'(wcnt - w0), 32'd0);
    rd(A_CITER, v); check("R9 count kept", v, 32'd4);
    wr(A_SRC, 32'h0);
    pulse(1); settle();
    rd(A_ERR, v); check("R9 sticky", v, 32'd1);
    check("R9 sticky blocks", 32'(wcnt - w0), 32'd0);
    wr(A_ERR, 32'd1); rd(A_ERR, v); check("R9 w1c", v, 32'd0);
    wr(A_DST, 32'h82);
    pulse(1); settle(); rd(A_ERR, v); check("R9 dst misaligned", v, 32'd2);
    wr(A_ERR, 32'd7); wr(A_DST, 32'h80); wr(A_NB, 32'd6);
    pulse(1); settle(); rd(A_ERR, v); check("R9 byte count multiple", v, 32'd4);
    wr(A_ERR, 32'd7); wr(A_NB, 32'd0);
    pulse(1); settle(); rd(A_ERR, v); check("R9 byte count zero", v, 32'd4);
    check("R9 no writes overall", 32'(wcnt - w0), 32'd0);
    wr(A_ERR, 32'd7); wr(A_NB, 32'd8);
    pulse(1); settle();
    rd(A_ERR, v); check("R9 clean run", v, 32'd0);
    rd(A_CITER, v); check("R9 runs after clear", v, 32'd3);
    check("R9 writes after clear", 32'(wcnt - w0), 32'd2);

    // R10: suspend and resume
    setup(32'h0, 32'h80, 32'h22, 32'h0004_0004, 32'd8, 32'd0, 32'd0, 32'd4, 32'd1);
    pulse(1); settle();
    wr(A_CTRL, 32'd0);
    w0 = wcnt;
    pulse(1); settle();
    rd(A_CITER, v); check("R10 ignored while disabled", v, 32'd3);
    check("R10 no writes disabled", 32'(wcnt - w0), 32'd0);
    wr(A_CTRL, 32'd1); settle();
    rd(A_CITER, v); check("R10 not latched", v, 32'd3);
    pulse(1); settle();
    rd(A_CITER, v); check("R10 resume count", v, 32'd2);
    rd(A_SRC, v); check("R10 resume address", v, 32'd16);

    // R11: back-to-back requests are all serviced once
    setup(32'h0, 32'h80, 32'h22, 32'h0004_0004, 32'd8, 32'd0, 32'd0, 32'd8, 32'd1);
    w0 = wcnt;
    pulse(3); settle();
    rd(A_CITER, v); check("R11 three loops", v, 32'd5);
    check("R11 write count", 32'(wcnt - w0), 32'd6);
    rd(A_SRC, v); check("R11 src", v, 32'd24);

    // R4: strided source, descending destination
    fill(8'h40, 8, 77); clr(8'hA0, 4);
    setup(32'h40, 32'hA3, 32'h0, 32'hFFFF_0002, 32'd4, 32'd0, 32'd0, 32'd1, 32'd1);
    pulse(1); settle();
    bad = 0;
    for (int j = 0; j < 4; j++) if (mem[8'(8'hA3 - j)] !== pat(2 * j, 77)) bad++;
    check("R4 stride data", 32'(bad), 32'd0);
    rd(A_SRC, v); check("R4 src stride", v, 32'h48);
    rd(A_DST, v); check("R4 dst negative stride", v, 32'h9F);
    check("R2 single-loop major", {31'd0, done}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule